// File: doc/BRIEF.md
# Flash Page-Program Handshake Sequencer

This block drives a single-lane SPI flash through one complete page program or sector erase. A one-cycle `start` strobe latches the operation, the target address, the address width and the requested byte count. The block then generates every chip-select frame on its own. For a program, it sends write-enable, then reads the status byte. It repeats that pair until the write-enable latch reads as set, and only then sends the program frame. The program frame carries the opcode, the address, and the payload bytes taken from a 64-byte local buffer. For an erase, it sends a single write-enable followed by the erase frame.

The address-width select chooses between the 3-byte and 4-byte opcode families. It is meant to be tied to a flash larger than 16 MiB. The SPI link runs in mode 0. The serial clock is the system clock divided by `2*DIV`. Chip select is held high for a fixed number of SPI periods between frames. Waiting for the flash to finish its internal program or erase is left to the surrounding logic.

Top module: `flash_pgm_seq`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, `busy` is 0 and `done` is 0.
- R2: Every operation begins with a frame holding only the write-enable byte 0x06.
- R3: For a program, each write-enable frame is followed by a two-byte status frame (0x05, then one byte read from `miso`). Bit 1 (mask 0x02) of the byte read is the latch flag. While that bit is 0, the write-enable and status pair is repeated; other status bits are disregarded.
- R4: The program frame starts with 0x02 followed by address bits 23:0 when `addr4`=0, or with 0x12 followed by address bits 31:0 when `addr4`=1. Address bytes go most significant first, directly after the opcode.
- R5: After the address, the program frame carries buffer bytes from index 0 upward. There are `min(len, 64)` of them, so `len`=0 gives no payload.
- R6: An erase (`op_erase`=1) is exactly two frames: 0x06, then 0xD8 with a 3-byte address (`addr4`=0) or 0xDC with a 4-byte address (`addr4`=1). No status read takes place.
- R7: Between consecutive frames `cs_n` stays high for at least `2*GAP_SPI*DIV` clock cycles. `sclk` is low whenever `cs_n` is high. `mosi` changes only while `sclk` is low, and bits go MSB first.
- R8: `busy` is 1 from the cycle after an accepted start. `done` is a one-cycle pulse in the same cycle that `cs_n` rises at the end of the final frame. `busy` drops exactly `2*GAP_SPI*DIV` cycles after `done`.
- R9: A `start` seen while `busy` is 1 is ignored. The frames of the running operation are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| op_erase | input | 1 | 1 = sector erase, 0 = page program |
| addr | input | 32 | Flash byte address |
| addr4 | input | 1 | 1 = 4-byte address opcodes |
| len | input | 8 | Requested payload bytes (capped at 64) |
| buf_we | input | 1 | Payload buffer write enable |
| buf_idx | input | 6 | Payload buffer write index |
| buf_data | input | 8 | Payload buffer write data |
| sclk | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to flash |
| miso | input | 1 | SPI data from flash |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final frame completed |

## Verification
The flash model on the bench can return a status byte without the latch bit for a chosen number of reads before returning a good one. Zero, one and two failed reads tell apart a sequencer that loops correctly from one that proceeds after the first read or never leaves. The failing value 0xFD has every bit except the latch set, which exposes a test of the wrong bit or of the whole byte. Program lengths of 0, 16, 64 and 100 separate correct payload counting from off-by-one errors and from a missing cap. Both address widths are run for program and erase, so a mix-up of opcode family or address byte count shows up in the captured frames. A second start issued mid-operation with different parameters shows whether the latched request is protected.

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq #(
  parameter int DIV       = 2,
  parameter int BUF_BYTES = 64,
  parameter int GAP_SPI   = 2
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         op_erase,
  input  logic [31:0]                  addr,
  input  logic                         addr4,
  input  logic [7:0]                   len,
  input  logic                         buf_we,
  input  logic [$clog2(BUF_BYTES)-1:0] buf_idx,
  input  logic [7:0]                   buf_data,
  output logic                         sclk,
  output logic                         cs_n,
  output logic                         mosi,
  input  logic                         miso,
  output logic                         busy,
  output logic                         done
);

  localparam int BW      = $clog2(BUF_BYTES);
  localparam int NW      = $clog2(BUF_BYTES + 6);
  localparam int GAP_CYC = 2 * DIV * GAP_SPI;
  localparam int DCW     = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int GCW     = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {C_WREN, C_RDSR, C_PROG, C_ERASE} cmd_t;
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;

  st_t             st;
  cmd_t            cmd, nxt_cmd;
  logic            erase_q, a4_q, last_q;
  logic [31:0]     addr_q;
  logic [NW-1:0]   cnt_q, byte_i, nxt_i, fl_m1;
  logic [2:0]      bit_i, alen_v, diff;
  logic [DCW-1:0]  div_c;
  logic [GCW-1:0]  gap_c;
  logic [7:0]      sh, nb;
  logic [1:0]      rx;
  logic [7:0]      mem [BUF_BYTES];

  function automatic logic [7:0] opc(cmd_t c, logic w4);
    case (c)
      C_WREN:  return 8'h06;
      C_RDSR:  return 8'h05;
      C_PROG:  return w4 ? 8'h12 : 8'h02;
      default: return w4 ? 8'hDC : 8'hD8;
    endcase
  endfunction

  assign cs_n   = (st != S_XFER);
  assign mosi   = sh[7] & ~cs_n;
  assign busy   = (st != S_IDLE);
  assign alen_v = a4_q ? 3'd4 : 3'd3;
  assign nxt_i  = byte_i + NW'(1);
  assign diff   = alen_v - nxt_i[2:0];

  always_comb begin
    case (cmd)
      C_WREN:  fl_m1 = '0;
      C_RDSR:  fl_m1 = NW'(1);
      C_ERASE: fl_m1 = NW'(alen_v);
      default: fl_m1 = NW'(alen_v) + cnt_q;
    endcase
    if (cmd == C_RDSR)               nb = 8'h00;
    else if (nxt_i <= NW'(alen_v))   nb = 8'(addr_q >> {diff, 3'b000});
    else                             nb = mem[BW'(nxt_i - NW'(alen_v) - NW'(1))];
    case (cmd)
      C_WREN:  nxt_cmd = erase_q ? C_ERASE : C_RDSR;
      C_RDSR:  nxt_cmd = rx[1] ? C_PROG : C_WREN;
      default: nxt_cmd = C_WREN;
    endcase
  end

  always_ff @(posedge clk)
    if (buf_we) mem[buf_idx] <= buf_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd <= C_WREN; erase_q <= 1'b0; a4_q <= 1'b0; last_q <= 1'b0;
      addr_q <= '0; cnt_q <= '0; byte_i <= '0; bit_i <= '0; div_c <= '0;
      gap_c <= '0; sh <= '0; rx <= '0; sclk <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          erase_q <= op_erase;
          a4_q    <= addr4;
          addr_q  <= addr;
          cnt_q   <= (len > 8'(BUF_BYTES)) ? NW'(BUF_BYTES) : NW'(len);
          cmd     <= C_WREN;
          sh      <= 8'h06;
          byte_i  <= '0;
          bit_i   <= 3'd7;
          div_c   <= '0;
          sclk    <= 1'b0;
          st      <= S_XFER;
        end
        S_XFER: if (div_c == DCW'(DIV - 1)) begin
          div_c <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[0], miso};
          end else begin
            sclk <= 1'b0;
            if (bit_i != 3'd0) begin
              bit_i <= bit_i - 3'd1;
              sh    <= {sh[6:0], 1'b0};
            end else if (byte_i == fl_m1) begin
              st     <= S_GAP;
              gap_c  <= '0;
              cmd    <= nxt_cmd;
              last_q <= (cmd == C_PROG) || (cmd == C_ERASE);
              done   <= (cmd == C_PROG) || (cmd == C_ERASE);
            end else begin
              byte_i <= nxt_i;
              sh     <= nb;
              bit_i  <= 3'd7;
            end
          end
        end else begin
          div_c <= div_c + DCW'(1);
        end
        default: if (gap_c == GCW'(GAP_CYC - 1)) begin
          if (last_q) st <= S_IDLE;
          else begin
            st     <= S_XFER;
            sh     <= opc(cmd, a4_q);
            byte_i <= '0;
            bit_i  <= 3'd7;
            div_c  <= '0;
          end
        end else begin
          gap_c <= gap_c + GCW'(1);
        end
      endcase
    end
  end

endmodule

module flash_pgm_seq_chk #(
  parameter int DIV     = 2,
  parameter int GAP_SPI = 2
)(
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic done
);
  localparam int GAP_CYC = 2 * DIV * GAP_SPI;
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          hi_run <= 16'(GAP_CYC);
    else if (!cs_n)      hi_run <= '0;
    else if (hi_run != 16'hFFFF) hi_run <= hi_run + 16'd1;

  a_r7_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_run >= 16'(GAP_CYC));
  a_r7_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r7_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_cs: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));
  a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
endmodule

bind flash_pgm_seq flash_pgm_seq_chk #(.DIV(DIV), .GAP_SPI(GAP_SPI)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .mosi(mosi), .busy(busy), .done(done));

// File: tb/flash_pgm_seq_test.sv
module flash_pgm_seq_test;
  localparam int DIV = 2, GAP_SPI = 2, GAP_CYC = 2 * DIV * GAP_SPI;

  logic clk = 0, rst_n = 0, start = 0, op_erase = 0, addr4 = 0, buf_we = 0, miso = 0;
  logic [31:0] addr = 0;
  logic [7:0]  len = 0, buf_data = 0;
  logic [5:0]  buf_idx = 0;
  logic sclk, cs_n, mosi, busy, done;

  int nchk = 0, nerr = 0;
  logic [7:0] fr [0:15][0:79];
  int flen [0:15];
  int nfr = 0, bitcnt = 0, rd_count = 0, bad_reads = 0, dones = 0;
  int hi_run = 0, min_gap = 1000;
  logic [7:0] cur = 0, bad_val = 0;
  logic [7:0] exp_b [0:79];
  int exp_n = 0;

  always #10 clk = ~clk;

  flash_pgm_seq #(.DIV(DIV), .BUF_BYTES(64), .GAP_SPI(GAP_SPI)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase), .addr(addr),
    .addr4(addr4), .len(len), .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .busy(busy), .done(done));

  always @(negedge cs_n) begin bitcnt = 0; cur = 0; end
  always @(posedge sclk) if (!cs_n) begin
    cur = {cur[6:0], mosi};
    bitcnt++;
    if (bitcnt % 8 == 0 && nfr < 16 && bitcnt / 8 <= 80) fr[nfr][bitcnt/8-1] = cur;
  end
  always @(posedge cs_n) if (bitcnt > 0 && nfr < 16) begin
    flen[nfr] = bitcnt / 8;
    if (fr[nfr][0] == 8'h05) rd_count++;
    nfr++;
    bitcnt = 0;
  end
  always @(negedge sclk) if (!cs_n && bitcnt >= 8 && bitcnt < 16 && nfr < 16 && fr[nfr][0] == 8'h05)
    miso = (rd_count < bad_reads) ? bad_val[15-bitcnt] : 8'h02 >> (15 - bitcnt);

  always @(negedge clk) begin
    if (done) dones++;
    if (busy) begin
      if (cs_n) hi_run++;
      else begin
        if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
        hi_run = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int j, input int seed);
    return 8'(j * 29 + seed * 3 + 1);
  endfunction

  task automatic cmp_frame(input int f, input string req);
    int bad_i = -1;
    if (flen[f] != exp_n) begin
      chk(0, req, $sformatf("frame %0d length", f), flen[f], exp_n);
      return;
    end
    for (int i = 0; i < exp_n; i++) if (bad_i < 0 && fr[f][i] !== exp_b[i]) bad_i = i;
    if (bad_i < 0) chk(1, req, "frame", 0, 0);
    else chk(0, req, $sformatf("frame %0d byte %0d", f, bad_i), fr[f][bad_i], exp_b[bad_i]);
  endtask

  task automatic do_op(input bit er, input logic [31:0] a, input bit a4, input int ln,
                       input int bad, input logic [7:0] badv, input bit poke);
    int seed = int'(a[7:0]);
    int cnt, alen, dn, base;
    logic prev_cs;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); buf_we = 1; buf_idx = 6'(i); buf_data = pat(i, seed);
    end
    @(negedge clk); buf_we = 0;
    nfr = 0; rd_count = 0; bad_reads = bad; bad_val = badv; min_gap = 1000; hi_run = 0; dones = 0;
    op_erase = er; addr = a; addr4 = a4; len = 8'(ln); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1, "R8", "busy after start", busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      // R9: a second request while busy with different parameters
      op_erase = ~er; addr = ~a; addr4 = ~a4; len = 8'd3; start = 1;
      @(negedge clk); start = 0;
    end
    do begin prev_cs = cs_n; @(negedge clk); end while (!done);
    chk(cs_n && !prev_cs, "R8", "done with cs_n rise", {prev_cs, cs_n}, 2'b01);
    cnt = 0;
    do begin
      @(negedge clk); cnt++;
      if (cnt == 1) chk(!done, "R8", "done single cycle", done, 0);
    end while (busy);
    chk(cnt == GAP_CYC, "R8", "busy tail after done", cnt, GAP_CYC);
    chk(dones == 1, "R8", "done pulse count", dones, 1);
    chk(min_gap >= GAP_CYC, "R7", "cs_n gap between frames", min_gap, GAP_CYC);
    alen = a4 ? 4 : 3;
    dn = (ln > 64) ? 64 : ln;
    chk(nfr == (er ? 2 : 2 * (bad + 1) + 1), er ? "R6" : "R3", "frame count", nfr, er ? 2 : 2 * (bad + 1) + 1);
    if (nfr != (er ? 2 : 2 * (bad + 1) + 1)) return;
    exp_n = 1; exp_b[0] = 8'h06;
    cmp_frame(0, "R2");
    if (!er) for (int k = 0; k <= bad; k++) begin
      if (k > 0) begin exp_n = 1; exp_b[0] = 8'h06; cmp_frame(2 * k, "R3"); end
      chk(flen[2*k+1] == 2 && fr[2*k+1][0] == 8'h05, "R3", "status frame", fr[2*k+1][0], 8'h05);
    end
    base = nfr - 1;
    exp_b[0] = er ? (a4 ? 8'hDC : 8'hD8) : (a4 ? 8'h12 : 8'h02);
    for (int k = 0; k < alen; k++) exp_b[1+k] = 8'(a >> (8 * (alen - 1 - k)));
    exp_n = 1 + alen;
    if (!er) begin
      for (int j = 0; j < dn; j++) exp_b[1+alen+j] = pat(j, seed);
      exp_n = 1 + alen + dn;
    end
    cmp_frame(base, er ? "R6" : (dn != ln || ln == 0) ? "R5" : "R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && busy == 0 && done == 0, "R1", "reset outputs",
        {cs_n, sclk, busy, done}, 4'b1000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    do_op(0, 32'h00A1_B2C3, 0, 16, 0, 8'h00, 0);   // R4 24-bit program
    do_op(0, 32'h1234_5678, 1, 64, 2, 8'h00, 0);   // R3 two failed status reads, R4 4-byte
    do_op(0, 32'h0003_0405, 0, 100, 1, 8'hFD, 0);  // R5 truncation, R3 latch bit only
    do_op(0, 32'h0000_0010, 1, 0, 0, 8'h00, 0);    // R5 empty payload
    do_op(1, 32'h0055_6677, 0, 8, 0, 8'h00, 0);    // R6 erase 3-byte
    do_op(1, 32'h89AB_CDEF, 1, 8, 0, 8'h00, 0);    // R6 erase 4-byte
    do_op(0, 32'h0022_3344, 0, 5, 1, 8'h00, 1);    // R9 start during busy
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule